// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central scoreboard of an issue stage. It takes one instruction per cycle in program order. Each instruction names a functional unit, an opcode, a destination register and two source registers. The block decides when each instruction may enter its unit, when that unit may read its operands, and when the finished unit may write its result to the register file. There is no renaming and no forwarding. Every hazard is resolved by holding the instruction in one phase:

- **Issue** holds on a busy unit or on a pending writer of the destination.
- **Operand read** holds until both sources are valid in the register file.
- **Result write** holds while another unit still has to read the old value of the destination.

Each unit has a record. It holds the opcode, the destination, both sources, a producing unit for each source and a readiness flag for each source. Each register has a pending flag and the unit that will produce it. The arithmetic lives outside the block. The block pulses a start line when a unit reads its operands and waits for a done pulse from that unit. It then grants at most one register-file write per cycle.

Units are numbered 0 (integer), 1 (multiply), 2 (add) and 3 (divide). Lower numbers win write conflicts.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: An instruction whose unit is busy is stalled (`instr_stall_o`=1). It is accepted in the cycle right after that unit's result write.
- R2: An instruction whose destination already has a pending writer is stalled. It is accepted in the cycle right after that write, so writes to one register occur in program order.
- R3: Issue is in order. An instruction behind a stalled one is not accepted before it, even if its own unit is free.
- R4: A read-after-write dependency never stalls issue. The consumer's `fu_start_o` rises in the cycle right after the producer's register write, and not earlier.
- R5: A finished unit withholds its write while another unit holds a ready but unread source equal to its destination. It writes in the cycle after that unit's `fu_start_o`.
- R6: At most one write is granted per cycle. When several units are eligible, the lowest unit index writes first and the other writes in a later cycle.
- R7: A `fu_done_i` pulse to a unit that is not executing is ignored. It causes no write, no start, and it does not shorten that unit's next operation.
- R8: After reset no unit is busy. The block shows no stall, no start and no write, even with a valid instruction presented.
- R9: Each write drives `rf_waddr_o` with the writing unit's destination and `rf_wunit_o` with that unit's index. The unit is free again in the next cycle.
- R10: `fu_start_o` pulses for exactly one cycle per accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction presented |
| instr_unit_i | input | 2 | Target unit index (0 int, 1 mul, 2 add, 3 div) |
| instr_op_i | input | 4 | Opcode passed to the unit |
| instr_dst_i | input | 3 | Destination register |
| instr_src1_i | input | 3 | First source register |
| instr_src2_i | input | 3 | Second source register |
| instr_stall_o | output | 1 | Instruction not accepted this cycle |
| fu_start_o | output | 4 | Per-unit operand-read and start pulse |
| fu_op_o | output | 16 | Per-unit opcode, unit n at bits 4n+3:4n |
| fu_done_i | input | 4 | Per-unit execution-finished pulse |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 3 | Register written |
| rf_wunit_o | output | 2 | Unit whose result is written |

## Verification
Two units can finish execution in the same cycle and compete for the single write port. The bench provokes this by issuing a two-cycle add and then a one-cycle integer operation back to back, so both done pulses line up. It judges the result by requiring the integer result to come off the expected-write queue first, and the add result to follow exactly one cycle later. A second overlap is also exercised: a blocked writer against a reader's operand fetch. The test checks that the write lands in the cycle after that fetch.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    FU_IDLE     = 2'd0,
    FU_WAIT_OPS = 2'd1,
    FU_EXEC     = 2'd2,
    FU_WAIT_WR  = 2'd3
  } fu_state_e;
endpackage

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl #(
  parameter int NUM_UNITS = 4,
  parameter int NUM_REGS  = 8,
  parameter int UNIT_W    = 2,
  parameter int REG_W     = 3
) (
  input  logic                 valid_i,
  input  logic [UNIT_W-1:0]    unit_i,
  input  logic [REG_W-1:0]     dst_i,
  input  logic [REG_W-1:0]     src1_i,
  input  logic [REG_W-1:0]     src2_i,
  input  logic [NUM_UNITS-1:0] unit_busy_i,
  input  logic [NUM_REGS-1:0]  reg_pend_i,
  input  logic [UNIT_W-1:0]    reg_prod_i [NUM_REGS],
  input  logic                 wr_valid_i,
  input  logic [UNIT_W-1:0]    wr_unit_i,
  output logic                 stall_o,
  output logic                 issue_o,
  output logic [NUM_UNITS-1:0] issue_sel_o,
  output logic [UNIT_W-1:0]    q1_o,
  output logic                 q1_vld_o,
  output logic [UNIT_W-1:0]    q2_o,
  output logic                 q2_vld_o
);
  logic [NUM_UNITS-1:0] sel;
  logic                 unit_ok;
  logic                 busy_hit;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_sel
    assign sel[u] = (unit_i == UNIT_W'(u));
  end

  assign unit_ok  = |sel;
  assign busy_hit = |(sel & unit_busy_i);

  // structural and write-after-write checks only
  assign stall_o     = valid_i && (!unit_ok || busy_hit || reg_pend_i[dst_i]);
  assign issue_o     = valid_i && !stall_o;
  assign issue_sel_o = issue_o ? sel : '0;

  // a producer writing in this very cycle counts as already done
  assign q1_o     = reg_prod_i[src1_i];
  assign q2_o     = reg_prod_i[src2_i];
  assign q1_vld_o = reg_pend_i[src1_i] && !(wr_valid_i && (wr_unit_i == q1_o));
  assign q2_vld_o = reg_pend_i[src2_i] && !(wr_valid_i && (wr_unit_i == q2_o));
endmodule

// File: rtl/sb_fu_rec.sv
module sb_fu_rec
  import sb_pkg::*;
#(
  parameter int UNIT_W = 2,
  parameter int REG_W  = 3,
  parameter int OP_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [REG_W-1:0]  dst_i,
  input  logic [REG_W-1:0]  src1_i,
  input  logic [REG_W-1:0]  src2_i,
  input  logic [UNIT_W-1:0] q1_i,
  input  logic              q1_vld_i,
  input  logic [UNIT_W-1:0] q2_i,
  input  logic              q2_vld_i,
  input  logic              wr_valid_i,
  input  logic [UNIT_W-1:0] wr_unit_i,
  input  logic              wr_grant_i,
  input  logic              done_i,
  output logic              busy_o,
  output logic              start_o,
  output logic              fin_o,
  output logic [OP_W-1:0]   op_o,
  output logic [REG_W-1:0]  dst_o,
  output logic [REG_W-1:0]  src1_o,
  output logic [REG_W-1:0]  src2_o,
  output logic              rdy1_o,
  output logic              rdy2_o
);
  fu_state_e         state_q;
  logic [OP_W-1:0]   op_q;
  logic [REG_W-1:0]  dst_q, src1_q, src2_q;
  logic [UNIT_W-1:0] q1_q, q2_q;
  logic              q1v_q, q2v_q, r1_q, r2_q;

  assign start_o = (state_q == FU_WAIT_OPS) && r1_q && r2_q;
  assign busy_o  = (state_q != FU_IDLE);
  assign fin_o   = (state_q == FU_WAIT_WR);
  assign op_o    = op_q;
  assign dst_o   = dst_q;
  assign src1_o  = src1_q;
  assign src2_o  = src2_q;
  assign rdy1_o  = r1_q;
  assign rdy2_o  = r2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FU_IDLE;
      op_q    <= '0;
      dst_q   <= '0;
      src1_q  <= '0;
      src2_q  <= '0;
      q1_q    <= '0;
      q2_q    <= '0;
      q1v_q   <= 1'b0;
      q2v_q   <= 1'b0;
      r1_q    <= 1'b0;
      r2_q    <= 1'b0;
    end else begin
      unique case (state_q)
        FU_IDLE: if (issue_i) begin
          state_q <= FU_WAIT_OPS;
          op_q    <= op_i;
          dst_q   <= dst_i;
          src1_q  <= src1_i;
          src2_q  <= src2_i;
          q1_q    <= q1_i;
          q2_q    <= q2_i;
          q1v_q   <= q1_vld_i;
          q2v_q   <= q2_vld_i;
          r1_q    <= !q1_vld_i;
          r2_q    <= !q2_vld_i;
        end
        FU_WAIT_OPS: begin
          if (start_o) begin
            state_q <= FU_EXEC;
            r1_q    <= 1'b0;  // operands consumed, stop blocking writers
            r2_q    <= 1'b0;
          end else begin
            if (q1v_q && wr_valid_i && (wr_unit_i == q1_q)) begin
              r1_q  <= 1'b1;
              q1v_q <= 1'b0;
            end
            if (q2v_q && wr_valid_i && (wr_unit_i == q2_q)) begin
              r2_q  <= 1'b1;
              q2v_q <= 1'b0;
            end
          end
        end
        FU_EXEC:    if (done_i) state_q <= FU_WAIT_WR;
        FU_WAIT_WR: if (wr_grant_i) state_q <= FU_IDLE;
        default:    state_q <= FU_IDLE;
      endcase
    end
  end

  // R10
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  // R9
  grant_fin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_grant_i |-> (state_q == FU_WAIT_WR));

  // R7
  stray_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && (state_q == FU_IDLE)) |=> (state_q != FU_WAIT_WR));
endmodule

// File: rtl/sb_wr_arb.sv
module sb_wr_arb #(
  parameter int NUM_UNITS = 4,
  parameter int UNIT_W    = 2,
  parameter int REG_W     = 3
) (
  input  logic [NUM_UNITS-1:0] fin_i,
  input  logic [REG_W-1:0]     dst_i  [NUM_UNITS],
  input  logic [REG_W-1:0]     src1_i [NUM_UNITS],
  input  logic [REG_W-1:0]     src2_i [NUM_UNITS],
  input  logic [NUM_UNITS-1:0] rdy1_i,
  input  logic [NUM_UNITS-1:0] rdy2_i,
  output logic [NUM_UNITS-1:0] grant_o,
  output logic                 we_o,
  output logic [UNIT_W-1:0]    unit_o,
  output logic [REG_W-1:0]     waddr_o
);
  logic [NUM_UNITS-1:0] war_blk;
  logic [NUM_UNITS-1:0] elig;
  logic [UNIT_W-1:0]    pick;

  // write-after-read: another unit still owes a read of the old value
  always_comb begin
    war_blk = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      for (int v = 0; v < NUM_UNITS; v++) begin
        if (v != u) begin
          if ((rdy1_i[v] && (src1_i[v] == dst_i[u])) ||
              (rdy2_i[v] && (src2_i[v] == dst_i[u])))
            war_blk[u] = 1'b1;
        end
      end
    end
  end

  assign elig = fin_i & ~war_blk;

  // fixed priority, lowest index wins
  always_comb begin
    pick = '0;
    for (int u = NUM_UNITS - 1; u >= 0; u--) begin
      if (elig[u]) pick = UNIT_W'(u);
    end
  end

  assign we_o    = |elig;
  assign unit_o  = pick;
  assign waddr_o = dst_i[pick];

  always_comb begin
    grant_o = '0;
    if (we_o) grant_o[pick] = 1'b1;
  end
endmodule

// File: rtl/sb_hazard_ctrl.sv
module sb_hazard_ctrl #(
  parameter int NUM_UNITS = 4,
  parameter int NUM_REGS  = 8,
  parameter int OP_W      = 4
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      instr_valid_i,
  input  logic [((NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1)-1:0] instr_unit_i,
  input  logic [OP_W-1:0]                           instr_op_i,
  input  logic [$clog2(NUM_REGS)-1:0]               instr_dst_i,
  input  logic [$clog2(NUM_REGS)-1:0]               instr_src1_i,
  input  logic [$clog2(NUM_REGS)-1:0]               instr_src2_i,
  output logic                                      instr_stall_o,
  output logic [NUM_UNITS-1:0]                      fu_start_o,
  output logic [NUM_UNITS*OP_W-1:0]                 fu_op_o,
  input  logic [NUM_UNITS-1:0]                      fu_done_i,
  output logic                                      rf_we_o,
  output logic [$clog2(NUM_REGS)-1:0]               rf_waddr_o,
  output logic [((NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1)-1:0] rf_wunit_o
);
  localparam int UNIT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
  localparam int REG_W  = $clog2(NUM_REGS);

  // register result status
  logic [NUM_REGS-1:0] pend_q;
  logic [UNIT_W-1:0]   prod_q [NUM_REGS];

  logic                 issue;
  logic [NUM_UNITS-1:0] issue_sel;
  logic [UNIT_W-1:0]    q1, q2;
  logic                 q1_vld, q2_vld;
  logic [NUM_UNITS-1:0] wr_grant;

  logic [NUM_UNITS-1:0] u_busy, u_fin, u_rdy1, u_rdy2;
  logic [OP_W-1:0]      u_op   [NUM_UNITS];
  logic [REG_W-1:0]     u_dst  [NUM_UNITS];
  logic [REG_W-1:0]     u_src1 [NUM_UNITS];
  logic [REG_W-1:0]     u_src2 [NUM_UNITS];

  sb_issue_ctl #(
    .NUM_UNITS(NUM_UNITS), .NUM_REGS(NUM_REGS), .UNIT_W(UNIT_W), .REG_W(REG_W)
  ) u_issue (
    .valid_i     (instr_valid_i),
    .unit_i      (instr_unit_i),
    .dst_i       (instr_dst_i),
    .src1_i      (instr_src1_i),
    .src2_i      (instr_src2_i),
    .unit_busy_i (u_busy),
    .reg_pend_i  (pend_q),
    .reg_prod_i  (prod_q),
    .wr_valid_i  (rf_we_o),
    .wr_unit_i   (rf_wunit_o),
    .stall_o     (instr_stall_o),
    .issue_o     (issue),
    .issue_sel_o (issue_sel),
    .q1_o        (q1),
    .q1_vld_o    (q1_vld),
    .q2_o        (q2),
    .q2_vld_o    (q2_vld)
  );

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    sb_fu_rec #(.UNIT_W(UNIT_W), .REG_W(REG_W), .OP_W(OP_W)) u_rec (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .issue_i    (issue_sel[g]),
      .op_i       (instr_op_i),
      .dst_i      (instr_dst_i),
      .src1_i     (instr_src1_i),
      .src2_i     (instr_src2_i),
      .q1_i       (q1),
      .q1_vld_i   (q1_vld),
      .q2_i       (q2),
      .q2_vld_i   (q2_vld),
      .wr_valid_i (rf_we_o),
      .wr_unit_i  (rf_wunit_o),
      .wr_grant_i (wr_grant[g]),
      .done_i     (fu_done_i[g]),
      .busy_o     (u_busy[g]),
      .start_o    (fu_start_o[g]),
      .fin_o      (u_fin[g]),
      .op_o       (u_op[g]),
      .dst_o      (u_dst[g]),
      .src1_o     (u_src1[g]),
      .src2_o     (u_src2[g]),
      .rdy1_o     (u_rdy1[g]),
      .rdy2_o     (u_rdy2[g])
    );
    assign fu_op_o[g*OP_W +: OP_W] = u_op[g];
  end

  sb_wr_arb #(.NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W), .REG_W(REG_W)) u_arb (
    .fin_i   (u_fin),
    .dst_i   (u_dst),
    .src1_i  (u_src1),
    .src2_i  (u_src2),
    .rdy1_i  (u_rdy1),
    .rdy2_i  (u_rdy2),
    .grant_o (wr_grant),
    .we_o    (rf_we_o),
    .unit_o  (rf_wunit_o),
    .waddr_o (rf_waddr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      for (int r = 0; r < NUM_REGS; r++) prod_q[r] <= '0;
    end else begin
      if (rf_we_o) pend_q[rf_waddr_o] <= 1'b0;
      if (issue) begin
        pend_q[instr_dst_i] <= 1'b1;
        prod_q[instr_dst_i] <= instr_unit_i;
      end
    end
  end

  // R1
  issue_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue |=> ((u_busy & $past(issue_sel)) == $past(issue_sel)));

  // R2
  issue_waw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue |-> !pend_q[instr_dst_i]);

  // R9
  write_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (pend_q[rf_waddr_o] && (prod_q[rf_waddr_o] == rf_wunit_o)));
endmodule

// File: tb/tb_sb_hazard_ctrl.sv
module tb_sb_hazard_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NU  = 4;
  localparam int NR  = 8;
  localparam int OPW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          iv;
  logic [1:0]    iu;
  logic [OPW-1:0] iop;
  logic [2:0]    id, is1, is2;
  logic          stall;
  logic [NU-1:0] fu_start;
  logic [NU*OPW-1:0] fu_op;
  logic [NU-1:0] model_done, inj_done, fu_done;
  logic          rf_we;
  logic [2:0]    rf_waddr;
  logic [1:0]    rf_wunit;

  int cyc = 0;
  int n_chk = 0, n_err = 0;
  int n_start = 0, n_issue = 0;
  int wr_cyc [NR];
  int st_cyc [NU];
  int exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign fu_done = model_done | inj_done;

  sb_hazard_ctrl #(.NUM_UNITS(NU), .NUM_REGS(NR), .OP_W(OPW)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .instr_valid_i(iv), .instr_unit_i(iu), .instr_op_i(iop),
    .instr_dst_i(id), .instr_src1_i(is1), .instr_src2_i(is2),
    .instr_stall_o(stall), .fu_start_o(fu_start), .fu_op_o(fu_op),
    .fu_done_i(fu_done), .rf_we_o(rf_we), .rf_waddr_o(rf_waddr),
    .rf_wunit_o(rf_wunit)
  );

  function automatic int lat(input int u);
    case (u)
      0: return 1;
      1: return 6;
      2: return 2;
      default: return 10;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_wr(input int r, input int u);
    exp_q.push_back(r * 16 + u);
  endtask

  task automatic issue(input int u, input int d, input int a, input int b,
                       output int ic, output int stl);
    @(negedge clk);
    iv = 1'b1; iu = 2'(u); id = 3'(d); is1 = 3'(a); is2 = 3'(b); iop = OPW'(u + 1);
    #1;
    stl = 0;
    while (stall) begin
      stl++;
      @(negedge clk);
      #1;
    end
    ic = cyc;
    n_issue++;
    @(posedge clk);
    #1 iv = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
  endtask

  initial forever @(posedge clk) cyc++;

  // fixed-latency unit models
  initial begin
    int cnt [NU];
    for (int u = 0; u < NU; u++) cnt[u] = 0;
    model_done = '0;
    forever begin
      @(negedge clk);
      for (int u = 0; u < NU; u++) begin
        if (cnt[u] > 0) begin
          cnt[u]--;
          model_done[u] = (cnt[u] == 0);
        end else begin
          model_done[u] = 1'b0;
        end
        if (fu_start[u]) cnt[u] = lat(u);
      end
    end
  end

  // monitor: pops expected writes
  initial forever begin
    @(negedge clk);
    if (rst_ni) begin
      for (int u = 0; u < NU; u++) begin
        if (fu_start[u]) begin
          st_cyc[u] = cyc;
          n_start++;
        end
      end
      if (rf_we) begin
        int got;
        got = int'(rf_waddr) * 16 + int'(rf_wunit);
        wr_cyc[rf_waddr] = cyc;
        if (exp_q.size() == 0) chk(1'b0, "R9 unexpected write", got, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(got == e, "R9 write reg*16+unit", got, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int i0, i1, i2, s0, s1, s2, w;
    iv = 1'b0; iu = '0; iop = '0; id = '0; is1 = '0; is2 = '0; inj_done = '0;
    for (int r = 0; r < NR; r++) wr_cyc[r] = -100;
    for (int u = 0; u < NU; u++) st_cyc[u] = -100;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R8: idle after reset
    @(negedge clk);
    iv = 1'b1; iu = 2'd1; id = 3'd0;
    #1;
    chk(!stall, "R8 stall after reset", int'(stall), 0);
    chk(fu_start == '0, "R8 start after reset", int'(fu_start), 0);
    chk(!rf_we, "R8 write after reset", int'(rf_we), 0);
    iv = 1'b0;

    // R1: structural stall on the multiplier
    expect_wr(1, 1); expect_wr(2, 1);
    issue(1, 1, 5, 6, i0, s0);
    issue(1, 2, 5, 6, i1, s1);
    chk(s1 > 0, "R1 second mul stalled", s1, 1);
    drain();
    chk(i1 == wr_cyc[1] + 1, "R1 accepted after write", i1, wr_cyc[1] + 1);

    // R2 + R3: WAW stall, younger instruction held behind it
    expect_wr(3, 3); expect_wr(3, 2); expect_wr(4, 0);
    issue(3, 3, 5, 6, i0, s0);
    issue(2, 3, 5, 6, i1, s1);
    w = wr_cyc[3];
    chk(i1 == w + 1, "R2 waw issue after write", i1, w + 1);
    issue(0, 4, 3, 5, i2, s2);
    chk(i2 == i1 + 1, "R3 int follows stalled add", i2, i1 + 1);
    chk(i2 > w, "R3 int not ahead of stall", i2, w + 1);
    drain();

    // R4: RAW waits in operand read, not at issue
    expect_wr(1, 1); expect_wr(2, 2);
    issue(1, 1, 5, 6, i0, s0);
    issue(2, 2, 1, 4, i1, s1);
    chk(s1 == 0, "R4 raw does not stall issue", s1, 0);
    chk(i1 == i0 + 1, "R4 back to back issue", i1, i0 + 1);
    drain();
    chk(st_cyc[2] == wr_cyc[1] + 1, "R4 start after producer write", st_cyc[2], wr_cyc[1] + 1);

    // R5: WAR holds the add result until divide reads r6
    expect_wr(2, 1); expect_wr(6, 2); expect_wr(7, 3);
    issue(1, 2, 5, 6, i0, s0);
    issue(3, 7, 2, 6, i1, s1);
    issue(2, 6, 1, 1, i2, s2);
    drain();
    chk(wr_cyc[6] == st_cyc[3] + 1, "R5 write after reader start", wr_cyc[6], st_cyc[3] + 1);
    chk(wr_cyc[6] > st_cyc[2] + 3, "R5 write was held", wr_cyc[6], st_cyc[2] + 4);

    // R6: add and int finish together, int wins
    expect_wr(2, 0); expect_wr(1, 2);
    issue(2, 1, 5, 6, i0, s0);
    issue(0, 2, 5, 6, i1, s1);
    drain();
    chk(wr_cyc[1] == wr_cyc[2] + 1, "R6 loser writes next cycle", wr_cyc[1], wr_cyc[2] + 1);

    // R7: stray done on an idle unit
    @(negedge clk); inj_done = 4'b0100;
    @(negedge clk); inj_done = '0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!rf_we && (fu_start == '0), "R7 stray done ignored", int'(rf_we), 0);
    end
    expect_wr(3, 2);
    issue(2, 3, 5, 6, i0, s0);
    drain();
    chk(wr_cyc[3] == st_cyc[2] + 3, "R7 no early finish", wr_cyc[3], st_cyc[2] + 3);

    // R10: one start per accepted instruction
    chk(n_start == n_issue, "R10 start count", n_start, n_issue);

    summary();
    $finish;
  end
endmodule